// File: doc/BRIEF.md
# Memory Ordering Fence Controller

This block sits between a core's in-order stream of memory requests and a memory port that can hold several requests in flight and may complete them in any order. Every request carries a 3-bit operation kind. The block decides, one request per cycle, whether the request at the head of the stream may go out now. It bases that decision on running counts of outstanding loads and stores, on per-class hold flags left behind by fences, and on whether an acquire or synchronization operation is still waiting for its response.

Fences never reach memory. Each one is accepted from the core as soon as no acquire or sync is pending, and it arms a hold on the class it orders. The hold keeps later requests of that class back until every request of that class issued before the fence has responded. Requests of the other class keep flowing. Synchronization operations and releases wait until the memory port is drained. Acquires go out at once. An acquire or a sync then blocks all further acceptance until its own response returns. Both sides use valid/ready handshakes. Completion arrives as a single-cycle response pulse that carries the kind of the operation that finished.

Top module: `mem_order_gate`

## Requirements
- R1: Operation kinds are encoded as 0 load, 1 store, 2 store fence, 3 load fence, 4 full fence, 5 sync, 6 acquire, 7 release. A fence is accepted (`req_ready` high) with `mem_valid` low, whatever `mem_ready` is, whenever no acquire or sync is pending.
- R2: After a store fence is accepted, no later store is offered to memory until every store outstanding at the fence has responded. Loads are still offered during that time. A store fence taken with no stores outstanding holds nothing.
- R3: After a load fence is accepted, no later load is offered to memory until every load outstanding at the fence has responded. Stores are still offered during that time.
- R4: A full fence arms both holds. Each hold clears on its own when its class has drained.
- R5: A sync is offered to memory only when no loads and no stores are outstanding. Once it has issued, no request of any kind is accepted until a response of kind sync arrives. Acceptance resumes in the following cycle.
- R6: An acquire is offered even while loads or stores are outstanding. Once it has issued, no request of any kind is accepted until a response of kind acquire arrives.
- R7: A release is offered only when no loads and no stores are outstanding. Requests after it are accepted without waiting for its response, and a release response changes no state.
- R8: Outstanding loads and outstanding stores are each counted in a CNT_W-bit counter (default 4). While a counter holds its maximum (15), requests of that class are not offered. The other class is unaffected.
- R9: A handshaken load or store increments its counter. A load or store response decrements it. A response that arrives while its counter is zero leaves the counter at zero.
- R10: While `rst` is high, `req_ready` and `mem_valid` are low. At a rising edge with `rst` high, both counters, both holds and the pending acquire/sync state are cleared.
- R11: `mem_kind` and `mem_addr` carry the head request's kind and address. `mem_valid` does not depend on `mem_ready`, and a memory-bound request is accepted from the core only in a cycle where `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_kind | input | 3 | Operation kind of the head request |
| req_addr | input | ADDR_W | Address of the head request |
| req_ready | output | 1 | Head request is consumed this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_kind | output | 3 | Operation kind sent to memory |
| mem_addr | output | ADDR_W | Address sent to memory |
| mem_ready | input | 1 | Memory port accepts the request |
| rsp_valid | input | 1 | Completion pulse from memory |
| rsp_kind | input | 3 | Kind of the completed operation |

## Verification
The bench builds the block with its default CNT_W of 4 and ADDR_W of 16. The narrow counter puts saturation within reach: the bench issues fifteen loads, sees the sixteenth held back while stores still pass, and then drains the loads. The address width is only carried through, and one directed check confirms it. With the default width, spurious responses at a zero count would visibly wrap the counter to its maximum, and that would block both a sync and further loads.

// File: rtl/mog_pkg.sv
package mog_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_SFENCE  = 3'd2,
    OP_LFENCE  = 3'd3,
    OP_FFENCE  = 3'd4,
    OP_SYNC    = 3'd5,
    OP_ACQUIRE = 3'd6,
    OP_RELEASE = 3'd7
  } mog_op_e;

  // class lanes used by counters and hold flags
  localparam int CLS_LD = 0;
  localparam int CLS_ST = 1;
  localparam int N_CLS  = 2;

endpackage

// File: rtl/mog_count.sv
module mog_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         full,
  output logic         zero,
  output logic         nxt_zero
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         dec_ok;

  // a completion with nothing outstanding is dropped
  assign dec_ok = dec && (cnt_q != ZERO);

  always_comb begin
    case ({inc, dec_ok})
      2'b10:   cnt_d = cnt_q + ONE;
      2'b01:   cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign full     = (cnt_q == MAXV);
  assign zero     = (cnt_q == ZERO);
  assign nxt_zero = (cnt_d == ZERO);
endmodule

// File: rtl/mog_hold.sv
module mog_hold (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic drained,
  output logic hold
);
  logic hold_q;

  // while held, no new request of this class issues, so the
  // counter only falls; the hold drops as the count reaches zero
  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= (hold_q || arm) && !drained;
  end

  assign hold = hold_q;
endmodule

// File: rtl/mog_sync_track.sv
module mog_sync_track
  import mog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_sync,
  input  logic       set_acq,
  input  logic       rsp_valid,
  input  logic [2:0] rsp_kind,
  output logic       pend
);
  logic    pend_q;
  logic    is_acq_q;
  mog_op_e wait_kind;
  logic    clr;

  assign wait_kind = is_acq_q ? OP_ACQUIRE : OP_SYNC;
  assign clr       = pend_q && rsp_valid && (rsp_kind == wait_kind);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      is_acq_q <= 1'b0;
    end else if (set_sync || set_acq) begin
      pend_q   <= 1'b1;
      is_acq_q <= set_acq;
    end else if (clr) begin
      pend_q   <= 1'b0;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/mog_issue.sv
module mog_issue
  import mog_pkg::*;
(
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic             mem_ready,
  input  logic             pend,
  input  logic [N_CLS-1:0] full_v,
  input  logic [N_CLS-1:0] zero_v,
  input  logic [N_CLS-1:0] hold_v,
  output logic             req_ready,
  output logic             mem_valid,
  output logic [N_CLS-1:0] inc_v,
  output logic [N_CLS-1:0] arm_v,
  output logic             set_sync,
  output logic             set_acq
);
  mog_op_e op;
  logic    to_mem;
  logic    ok;
  logic    open;
  logic    take;
  logic    drained;

  assign op      = mog_op_e'(req_kind);
  assign open    = !rst && !pend;
  assign drained = &zero_v;

  always_comb begin
    to_mem = 1'b1;
    ok     = 1'b1;
    case (op)
      OP_LOAD:    ok = !hold_v[CLS_LD] && !full_v[CLS_LD];
      OP_STORE:   ok = !hold_v[CLS_ST] && !full_v[CLS_ST];
      OP_SFENCE,
      OP_LFENCE,
      OP_FFENCE:  to_mem = 1'b0;
      OP_SYNC,
      OP_RELEASE: ok = drained;
      default:    ok = 1'b1;
    endcase
  end

  assign mem_valid = req_valid && open && ok && to_mem;
  assign req_ready = open && ok && (to_mem ? mem_ready : 1'b1);
  assign take      = req_valid && req_ready;

  assign inc_v[CLS_LD] = take && (op == OP_LOAD);
  assign inc_v[CLS_ST] = take && (op == OP_STORE);
  assign arm_v[CLS_LD] = take && ((op == OP_LFENCE) || (op == OP_FFENCE));
  assign arm_v[CLS_ST] = take && ((op == OP_SFENCE) || (op == OP_FFENCE));
  assign set_sync      = take && (op == OP_SYNC);
  assign set_acq       = take && (op == OP_ACQUIRE);
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mog_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_valid,
  output logic [2:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_kind
);
  logic [CNT_W-1:0] cnt_a [N_CLS];
  logic [N_CLS-1:0] full_v, zero_v, nzero_v, hold_v, inc_v, dec_v, arm_v;
  logic             pend, set_sync, set_acq;
  logic [CNT_W-1:0] ld_cnt, st_cnt;

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    localparam mog_op_e DONE_OP = (c == CLS_LD) ? OP_LOAD : OP_STORE;

    assign dec_v[c] = rsp_valid && (rsp_kind == DONE_OP);

    mog_count #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .inc      (inc_v[c]),
      .dec      (dec_v[c]),
      .cnt      (cnt_a[c]),
      .full     (full_v[c]),
      .zero     (zero_v[c]),
      .nxt_zero (nzero_v[c])
    );

    mog_hold hold_i (
      .clk     (clk),
      .rst     (rst),
      .arm     (arm_v[c]),
      .drained (nzero_v[c]),
      .hold    (hold_v[c])
    );
  end

  mog_sync_track trk_i (
    .clk       (clk),
    .rst       (rst),
    .set_sync  (set_sync),
    .set_acq   (set_acq),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .pend      (pend)
  );

  mog_issue iss_i (
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .mem_ready (mem_ready),
    .pend      (pend),
    .full_v    (full_v),
    .zero_v    (zero_v),
    .hold_v    (hold_v),
    .req_ready (req_ready),
    .mem_valid (mem_valid),
    .inc_v     (inc_v),
    .arm_v     (arm_v),
    .set_sync  (set_sync),
    .set_acq   (set_acq)
  );

  assign mem_kind = req_kind;
  assign mem_addr = req_addr;
  assign ld_cnt   = cnt_a[CLS_LD];
  assign st_cnt   = cnt_a[CLS_ST];
endmodule

// File: rtl/mog_checker.sv
module mog_checker
  import mog_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_valid,
  input logic [2:0]       mem_kind,
  input logic             mem_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_kind,
  input logic [CNT_W-1:0] ld_cnt,
  input logic [CNT_W-1:0] st_cnt,
  input logic [1:0]       hold_v,
  input logic             pend
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic is_mem;
  assign is_mem = !(mem_kind inside {OP_SFENCE, OP_LFENCE, OP_FFENCE});

  p_fence_no_mem_r1: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> is_mem);

  p_store_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_kind == OP_STORE) |-> !hold_v[CLS_ST]);

  p_load_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_kind == OP_LOAD) |-> !hold_v[CLS_LD]);

  p_sync_drained_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_kind == OP_SYNC) |-> (ld_cnt == '0 && st_cnt == '0));

  p_pend_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    pend |-> !req_ready);

  p_release_drained_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_kind == OP_RELEASE) |-> (ld_cnt == '0 && st_cnt == '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_cnt == MAXV) |-> !(mem_valid && mem_kind == OP_LOAD));

  p_load_count_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_kind == OP_LOAD &&
     !(rsp_valid && rsp_kind == OP_LOAD)) |=> (ld_cnt == $past(ld_cnt) + ONE));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |-> (!req_ready && !mem_valid));

  p_accept_needs_mem_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && is_mem) |-> (mem_valid && mem_ready));
endmodule

bind mem_order_gate mog_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_kind  (mem_kind),
  .mem_ready (mem_ready),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .ld_cnt    (ld_cnt),
  .st_cnt    (st_cnt),
  .hold_v    (hold_v),
  .pend      (pend)
);

// File: tb/mem_order_gate_tb_top.sv
`timescale 1ns/1ps
module mem_order_gate_tb_top;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 16;
  localparam int NV     = 39;

  localparam logic [2:0] LD = 3'd0, ST = 3'd1, SF = 3'd2, LF = 3'd3,
                         FF = 3'd4, SY = 3'd5, AQ = 3'd6, RL = 3'd7;

  // {kind, mem_ready, rsp_valid, rsp_kind, exp_req_ready, exp_mem_valid}
  localparam logic [9:0] VEC [NV] = '{
    {ST,1'b1,1'b0,LD,1'b1,1'b1},  // 0  R2 store out
    {ST,1'b0,1'b0,LD,1'b0,1'b1},  // 1  R11 memory not ready
    {ST,1'b1,1'b0,LD,1'b1,1'b1},  // 2  two stores out
    {SF,1'b1,1'b0,LD,1'b1,1'b0},  // 3  R1 store fence taken
    {LD,1'b1,1'b0,LD,1'b1,1'b1},  // 4  R2 load passes
    {ST,1'b1,1'b0,LD,1'b0,1'b0},  // 5  R2 store held
    {ST,1'b1,1'b1,ST,1'b0,1'b0},  // 6
    {ST,1'b1,1'b1,ST,1'b0,1'b0},  // 7  last store drains
    {ST,1'b1,1'b0,LD,1'b1,1'b1},  // 8  hold released
    {LF,1'b1,1'b0,LD,1'b1,1'b0},  // 9  R3 load fence
    {LD,1'b1,1'b0,LD,1'b0,1'b0},  // 10 load held
    {ST,1'b1,1'b0,LD,1'b1,1'b1},  // 11 store passes
    {LD,1'b1,1'b1,LD,1'b0,1'b0},  // 12 load drains
    {LD,1'b1,1'b0,LD,1'b1,1'b1},  // 13 load released
    {FF,1'b1,1'b0,LD,1'b1,1'b0},  // 14 R4 full fence
    {ST,1'b1,1'b0,LD,1'b0,1'b0},  // 15
    {LD,1'b1,1'b1,LD,1'b0,1'b0},  // 16 loads drain
    {LD,1'b1,1'b0,LD,1'b1,1'b1},  // 17 load hold gone, store hold stays
    {ST,1'b1,1'b1,ST,1'b0,1'b0},  // 18
    {ST,1'b1,1'b1,ST,1'b0,1'b0},  // 19 stores drain
    {SY,1'b1,1'b0,LD,1'b0,1'b0},  // 20 R5 sync waits for load
    {SY,1'b1,1'b1,LD,1'b0,1'b0},  // 21
    {SY,1'b1,1'b0,LD,1'b1,1'b1},  // 22 sync out
    {LD,1'b1,1'b0,LD,1'b0,1'b0},  // 23 blocked by sync
    {LD,1'b1,1'b1,SY,1'b0,1'b0},  // 24 sync done
    {LD,1'b1,1'b0,LD,1'b1,1'b1},  // 25 R6 resumes
    {AQ,1'b1,1'b0,LD,1'b1,1'b1},  // 26 acquire with load outstanding
    {ST,1'b1,1'b0,LD,1'b0,1'b0},  // 27
    {SF,1'b1,1'b0,LD,1'b0,1'b0},  // 28 fence also blocked
    {ST,1'b1,1'b1,AQ,1'b0,1'b0},  // 29 acquire done
    {ST,1'b1,1'b0,LD,1'b1,1'b1},  // 30
    {RL,1'b1,1'b0,LD,1'b0,1'b0},  // 31 R7 release waits
    {RL,1'b1,1'b1,LD,1'b0,1'b0},  // 32
    {RL,1'b1,1'b1,ST,1'b0,1'b0},  // 33
    {RL,1'b1,1'b0,LD,1'b1,1'b1},  // 34 release out
    {LD,1'b1,1'b0,LD,1'b1,1'b1},  // 35 no wait on release
    {LD,1'b1,1'b1,RL,1'b1,1'b1},  // 36 release response ignored
    {SF,1'b0,1'b0,LD,1'b1,1'b0},  // 37 fence with no stores
    {ST,1'b1,1'b0,LD,1'b1,1'b1}   // 38 nothing held
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [2:0]        req_kind = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              mem_valid;
  logic [2:0]        mem_kind;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready = 1'b0;
  logic              rsp_valid = 1'b0;
  logic [2:0]        rsp_kind = 3'd0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mem_order_gate #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_addr(mem_addr),
    .mem_ready(mem_ready),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive inputs at the falling edge, then let outputs settle
  task automatic step(input logic v, input logic [2:0] k, input logic mr,
                      input logic rv, input logic [2:0] rk);
    @(negedge clk);
    req_valid = v; req_kind = k; mem_ready = mr;
    rsp_valid = rv; rsp_kind = rk;
    #1;
  endtask

  function automatic string req_of(input int i);
    if (i <= 8)  return "R2";
    if (i <= 13) return "R3";
    if (i <= 19) return "R4";
    if (i <= 24) return "R5";
    if (i <= 30) return "R6";
    return "R7";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    step(1'b1, LD, 1'b1, 1'b0, LD);
    check("R10", "ready in reset", req_ready, 0);
    check("R10", "mem_valid in reset", mem_valid, 0);
    step(1'b0, LD, 1'b0, 1'b0, LD);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VEC[i];
      step(1'b1, v[9:7], v[6], v[5], v[4:2]);
      check(req_of(i), $sformatf("vec %0d req_ready", i), req_ready, v[1]);
      check(req_of(i), $sformatf("vec %0d mem_valid", i), mem_valid, v[0]);
    end

    // R11 kind and address pass through; loads now 3, stores 1
    req_addr = 16'hA5C3;
    step(1'b1, LD, 1'b1, 1'b0, LD);
    check("R11", "mem_addr", mem_addr, 32'hA5C3);
    check("R11", "mem_kind", mem_kind, LD);
    for (int i = 0; i < 3; i++) step(1'b0, LD, 1'b1, 1'b1, LD);
    step(1'b0, LD, 1'b1, 1'b1, ST);

    // R1 full fence accepted with memory not ready
    step(1'b1, FF, 1'b0, 1'b0, LD);
    check("R1", "fence ready", req_ready, 1);
    check("R1", "fence mem_valid", mem_valid, 0);

    // R8 saturation of the load counter
    for (int i = 0; i < 15; i++) begin
      step(1'b1, LD, 1'b1, 1'b0, LD);
      check("R8", $sformatf("load %0d accepted", i), req_ready, 1);
    end
    step(1'b1, LD, 1'b1, 1'b0, LD);
    check("R8", "load at max ready", req_ready, 0);
    check("R8", "load at max mem_valid", mem_valid, 0);
    step(1'b1, ST, 1'b1, 1'b0, LD);
    check("R8", "store with loads full", req_ready, 1);
    step(1'b1, LD, 1'b1, 1'b1, LD);
    check("R9", "load while response lands", req_ready, 0);
    step(1'b1, LD, 1'b1, 1'b0, LD);
    check("R9", "load after one response", req_ready, 1);
    for (int i = 0; i < 15; i++) step(1'b0, LD, 1'b1, 1'b1, LD);
    step(1'b0, LD, 1'b1, 1'b1, ST);

    // R9 spurious responses at zero must not wrap
    step(1'b0, LD, 1'b1, 1'b1, LD);
    step(1'b0, LD, 1'b1, 1'b1, ST);
    step(1'b1, LD, 1'b1, 1'b0, LD);
    check("R9", "load after spurious response", mem_valid, 1);
    step(1'b0, LD, 1'b1, 1'b1, LD);
    step(1'b1, SY, 1'b1, 1'b0, LD);
    check("R9", "sync after spurious response", mem_valid, 1);
    step(1'b0, LD, 1'b1, 1'b1, SY);

    // R10 reset clears outstanding and pending state
    step(1'b1, LD, 1'b1, 1'b0, LD);
    step(1'b1, AQ, 1'b1, 1'b0, LD);
    check("R6", "acquire issued", mem_valid, 1);
    step(1'b1, LD, 1'b1, 1'b0, LD);
    rst = 1'b1;
    #1;
    check("R10", "ready with rst", req_ready, 0);
    check("R10", "mem_valid with rst", mem_valid, 0);
    step(1'b1, LD, 1'b1, 1'b0, LD);
    step(1'b1, SY, 1'b1, 1'b0, LD);
    rst = 1'b0;
    #1;
    check("R10", "sync after reset ready", req_ready, 1);
    check("R10", "sync after reset mem_valid", mem_valid, 1);
    step(1'b0, LD, 1'b0, 1'b0, LD);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule